// File: doc/BRIEF.md
# Two-by-two time-domain channel filter core with banked coefficients

This block models a radio channel with two transmit and two receive streams. Two signed sample streams enter together, one pair per clock while `in_valid` is high. Each stream feeds a delay line. Four nine-tap FIR filters, one for each transmit-to-receive path, weight those delay lines. Each output is the sum of the two paths that reach its receiver. That sum is scaled by a power-of-two gain and registered into a 35-bit result.

A host loads a complete channel profile through a word-write port while the current profile stays in use. A profile is 36 coefficient words plus one gain exponent, and every write goes to a shadow bank. A one-cycle `refresh` pulse swaps the shadow and active banks between two samples, so every output sample uses exactly one profile. The gain exponent that produced each output sample is presented with it, so a later stage can divide the gain back out.

Top module: `mimo_fir_core`

## Requirements
- R1: After reset, `out_valid`, `y1`, `y2` and `kh_out` are zero. Both coefficient banks, both gain exponents and both delay lines start at zero.
- R2: Tap 0 weights the sample accepted in the same cycle, and tap k weights the sample accepted k samples earlier. Samples not yet received count as zero. The output for that sample is y1 = 2^kh · Σk (h11[k]·x1 + h12[k]·x2) and y2 = 2^kh · Σk (h21[k]·x1 + h22[k]·x2), with all values signed two's complement. Each result wraps modulo 2^35.
- R3: An output pair appears on the clock after its sample is accepted, with `out_valid` high for exactly that cycle. `out_valid` is low after any cycle in which no sample was accepted.
- R4: A cycle without `in_valid` does not shift either delay line, and `y1`, `y2` and `kh_out` keep their values.
- R5: Coefficient word address = 9·filter + tap, where filter 0 is h11, 1 is h12, 2 is h21 and 3 is h22. Address 36 loads the gain exponent from the low 3 bits of `cw_data`.
- R6: Writes only change the shadow bank. The outputs for samples accepted before the next refresh do not depend on them.
- R7: `refresh` swaps the two banks, gain exponent included. A sample accepted in the refresh cycle still uses the old profile, and samples accepted in later cycles use the new one.
- R8: A write issued in the same cycle as `refresh` lands in the bank that becomes active.
- R9: `kh_out` carries the gain exponent that was applied to the `y1`/`y2` pair it accompanies.
- R10: After a swap, the previously active profile sits in the shadow bank unchanged, so a second refresh without writes restores it.
- R11: Writes to addresses 37 to 63 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample pair is accepted this cycle |
| x1 | input | 14 | Stream 1 sample, signed |
| x2 | input | 14 | Stream 2 sample, signed |
| cw_en | input | 1 | Profile word write strobe |
| cw_addr | input | 6 | Profile word address |
| cw_data | input | 16 | Coefficient (signed) or gain exponent |
| refresh | input | 1 | Single-cycle bank swap |
| out_valid | output | 1 | y1/y2/kh_out hold a new result |
| y1 | output | 35 | Receiver 1 sum, signed |
| y2 | output | 35 | Receiver 2 sum, signed |
| kh_out | output | 3 | Gain exponent applied to this result |

## Verification
The bench probes the swap boundary in several ways:
- A refresh coinciding with an accepted sample catches a design that switches banks one sample early, because that sample would come out weighted by the new profile.
- A write issued with the refresh catches a design that sends it to the wrong bank; the new profile would then be missing that word.
- Unit impulses on each input walk the taps out one at a time, which exposes a wrong address map or a reversed tap order.
- Idle gaps in the stream expose a delay line that shifts without valid data.
- Full-scale negative samples and coefficients at the largest exponent force 35-bit wraparound, where a narrow or unsigned product would give a different result.

// File: rtl/mfc_pkg.sv
package mfc_pkg;
  // path order inside a profile; receiver r uses paths 2r (from x1) and 2r+1 (from x2)
  typedef enum logic [1:0] {
    PATH_H11 = 2'd0,
    PATH_H12 = 2'd1,
    PATH_H21 = 2'd2,
    PATH_H22 = 2'd3
  } path_e;

  localparam int unsigned NUM_PATHS = 4;
  localparam int unsigned NUM_STREAMS = 2;
endpackage

// File: rtl/mfc_delay_line.sv
module mfc_delay_line #(
  parameter int unsigned SAMP_W = 14,
  parameter int unsigned TAPS   = 9
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           shift_en,
  input  logic [SAMP_W-1:0]              din,
  output logic [TAPS-1:0][SAMP_W-1:0]    win
);
  localparam int unsigned HIST = TAPS - 1;

  logic [HIST-1:0][SAMP_W-1:0] hist;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hist <= '0;
    end else if (shift_en) begin
      hist[0] <= din;
      for (int k = 1; k < HIST; k++) begin
        hist[k] <= hist[k-1];
      end
    end
  end

  // tap 0 is the sample offered this cycle
  always_comb begin
    win[0] = din;
    for (int k = 1; k < TAPS; k++) begin
      win[k] = hist[k-1];
    end
  end
endmodule

// File: rtl/mfc_coef_bank.sv
module mfc_coef_bank #(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned TAPS   = 9,
  parameter int unsigned KH_W   = 3,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             wr_en,
  input  logic [ADDR_W-1:0]                                wr_addr,
  input  logic [COEF_W-1:0]                                wr_data,
  input  logic                                             swap,
  output logic [mfc_pkg::NUM_PATHS*TAPS-1:0][COEF_W-1:0]   act_coef,
  output logic [KH_W-1:0]                                  act_kh,
  output logic                                             bank_sel
);
  localparam int unsigned NWORDS = mfc_pkg::NUM_PATHS * TAPS;
  localparam int unsigned IDX_W  = $clog2(NWORDS);

  logic [1:0][NWORDS-1:0][COEF_W-1:0] mem;
  logic [1:0][KH_W-1:0]               kh;
  logic                               sel;
  logic                               hit_coef;
  logic                               hit_kh;

  assign hit_coef = wr_en && (wr_addr < ADDR_W'(NWORDS));
  assign hit_kh   = wr_en && (wr_addr == ADDR_W'(NWORDS));

  // writes address the bank that is shadow before this edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem <= '0;
      kh  <= '0;
      sel <= 1'b0;
    end else begin
      if (hit_coef) mem[~sel][wr_addr[IDX_W-1:0]] <= wr_data;
      if (hit_kh)   kh[~sel] <= wr_data[KH_W-1:0];
      if (swap)     sel <= ~sel;
    end
  end

  assign act_coef = mem[sel];
  assign act_kh   = kh[sel];
  assign bank_sel = sel;
endmodule

// File: rtl/mfc_fir_pair.sv
module mfc_fir_pair #(
  parameter int unsigned SAMP_W = 14,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned TAPS   = 9,
  parameter int unsigned KH_W   = 3,
  parameter int unsigned ACC_W  = 35
) (
  input  logic [TAPS-1:0][SAMP_W-1:0] win_a,
  input  logic [TAPS-1:0][SAMP_W-1:0] win_b,
  input  logic [TAPS-1:0][COEF_W-1:0] coef_a,
  input  logic [TAPS-1:0][COEF_W-1:0] coef_b,
  input  logic [KH_W-1:0]             kh,
  output logic [ACC_W-1:0]            sum
);
  // one scaled product, sign-extended to the accumulator width
  function automatic logic signed [ACC_W-1:0] tap_term(
    input logic signed [COEF_W-1:0] c,
    input logic signed [SAMP_W-1:0] s,
    input logic [KH_W-1:0]          e
  );
    logic signed [ACC_W-1:0] p;
    p = ACC_W'(c) * ACC_W'(s);
    return p <<< e;
  endfunction

  logic signed [ACC_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int t = 0; t < TAPS; t++) begin
      acc = acc + tap_term($signed(coef_a[t]), $signed(win_a[t]), kh)
                + tap_term($signed(coef_b[t]), $signed(win_b[t]), kh);
    end
  end

  assign sum = acc;
endmodule

// File: rtl/mimo_fir_core.sv
module mimo_fir_core #(
  parameter int unsigned SAMP_W = 14,
  parameter int unsigned COEF_W = 16,
  parameter int unsigned TAPS   = 9,
  parameter int unsigned KH_W   = 3,
  parameter int unsigned ACC_W  = 35,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] x1,
  input  logic [SAMP_W-1:0] x2,
  input  logic              cw_en,
  input  logic [ADDR_W-1:0] cw_addr,
  input  logic [COEF_W-1:0] cw_data,
  input  logic              refresh,
  output logic              out_valid,
  output logic [ACC_W-1:0]  y1,
  output logic [ACC_W-1:0]  y2,
  output logic [KH_W-1:0]   kh_out
);
  import mfc_pkg::*;

  localparam int unsigned NWORDS = NUM_PATHS * TAPS;

  logic [NUM_STREAMS-1:0][SAMP_W-1:0]            xin;
  logic [NUM_STREAMS-1:0][TAPS-1:0][SAMP_W-1:0]  win;
  logic [NWORDS-1:0][COEF_W-1:0]                 act_coef;
  logic [KH_W-1:0]                               act_kh;
  logic                                          bank_sel;
  logic [NUM_STREAMS-1:0][ACC_W-1:0]             sums;
  logic [NUM_STREAMS-1:0][ACC_W-1:0]             y_q;
  logic [KH_W-1:0]                               kh_q;
  logic                                          ov_q;

  assign xin = {x2, x1};

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_line
    mfc_delay_line #(.SAMP_W(SAMP_W), .TAPS(TAPS)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (in_valid),
      .din      (xin[s]),
      .win      (win[s])
    );
  end

  mfc_coef_bank #(.COEF_W(COEF_W), .TAPS(TAPS), .KH_W(KH_W), .ADDR_W(ADDR_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (cw_en),
    .wr_addr  (cw_addr),
    .wr_data  (cw_data),
    .swap     (refresh),
    .act_coef (act_coef),
    .act_kh   (act_kh),
    .bank_sel (bank_sel)
  );

  for (genvar r = 0; r < NUM_STREAMS; r++) begin : g_rx
    mfc_fir_pair #(
      .SAMP_W(SAMP_W), .COEF_W(COEF_W), .TAPS(TAPS), .KH_W(KH_W), .ACC_W(ACC_W)
    ) u_pair (
      .win_a  (win[0]),
      .win_b  (win[1]),
      .coef_a (act_coef[(2*r)*TAPS +: TAPS]),
      .coef_b (act_coef[(2*r+1)*TAPS +: TAPS]),
      .kh     (act_kh),
      .sum    (sums[r])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_q  <= '0;
      kh_q <= '0;
      ov_q <= 1'b0;
    end else begin
      ov_q <= in_valid;
      if (in_valid) begin
        y_q  <= sums;
        kh_q <= act_kh;
      end
    end
  end

  assign y1        = y_q[0];
  assign y2        = y_q[1];
  assign kh_out    = kh_q;
  assign out_valid = ov_q;
endmodule

// File: rtl/mfc_core_chk.sv
module mfc_core_chk #(
  parameter int unsigned COEF_W = 16,
  parameter int unsigned TAPS   = 9,
  parameter int unsigned KH_W   = 3,
  parameter int unsigned ACC_W  = 35
) (
  input logic                                           clk,
  input logic                                           rst_n,
  input logic                                           in_valid,
  input logic                                           refresh,
  input logic                                           bank_sel,
  input logic [mfc_pkg::NUM_PATHS*TAPS-1:0][COEF_W-1:0] act_coef,
  input logic [KH_W-1:0]                                act_kh,
  input logic                                           out_valid,
  input logic [ACC_W-1:0]                               y1,
  input logic [ACC_W-1:0]                               y2,
  input logic [KH_W-1:0]                                kh_out
);
  AST_VALID_FOLLOWS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R3
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R3
  AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(y1) && $stable(y2) && $stable(kh_out))); // R4
  AST_ACTIVE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !refresh |=> ($stable(act_coef) && $stable(act_kh))); // R6
  AST_SWAP_FLIPS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
    refresh |=> (bank_sel != $past(bank_sel))); // R7
  AST_GAIN_TAGS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (kh_out == $past(act_kh))); // R9
endmodule

bind mimo_fir_core mfc_core_chk #(
  .COEF_W(COEF_W), .TAPS(TAPS), .KH_W(KH_W), .ACC_W(ACC_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .refresh   (refresh),
  .bank_sel  (bank_sel),
  .act_coef  (act_coef),
  .act_kh    (act_kh),
  .out_valid (out_valid),
  .y1        (y1),
  .y2        (y2),
  .kh_out    (kh_out)
);

// File: tb/mimo_fir_core_tb.sv
module mimo_fir_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 9;
  localparam int NW = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [13:0] x1 = '0, x2 = '0;
  logic cw_en = 1'b0;
  logic [5:0] cw_addr = '0;
  logic [15:0] cw_data = '0;
  logic refresh = 1'b0;
  logic out_valid;
  logic [34:0] y1, y2;
  logic [2:0] kh_out;

  mimo_fir_core u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x1(x1), .x2(x2),
    .cw_en(cw_en), .cw_addr(cw_addr), .cw_data(cw_data), .refresh(refresh),
    .out_valid(out_valid), .y1(y1), .y2(y2), .kh_out(kh_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  // behavioural reference state
  int  mb [2][NW];
  int  mk [2];
  int  msel = 0;
  int  hx1 [NT];
  int  hx2 [NT];
  logic [34:0] ey1 = '0, ey2 = '0;
  logic [2:0]  ekh = '0;
  logic        eov = 1'b0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected <100000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model(input bit v, input int a, input int b, input bit we,
                       input int ad, input logic [15:0] d, input bit rf);
    longint s1, s2;
    int w1 [NT];
    int w2 [NT];
    if (v) begin
      w1[0] = a; w2[0] = b;
      for (int k = 1; k < NT; k++) begin w1[k] = hx1[k-1]; w2[k] = hx2[k-1]; end
      s1 = 0; s2 = 0;
      for (int k = 0; k < NT; k++) begin
        s1 += longint'(mb[msel][k])      * w1[k] + longint'(mb[msel][NT+k])   * w2[k];
        s2 += longint'(mb[msel][2*NT+k]) * w1[k] + longint'(mb[msel][3*NT+k]) * w2[k];
      end
      s1 = s1 * (longint'(1) << mk[msel]);
      s2 = s2 * (longint'(1) << mk[msel]);
      ey1 = s1[34:0];
      ey2 = s2[34:0];
      ekh = 3'(mk[msel]);
      for (int k = NT-1; k > 0; k--) begin hx1[k] = hx1[k-1]; hx2[k] = hx2[k-1]; end
      hx1[0] = a; hx2[0] = b;
    end
    eov = v;
    if (we) begin
      if (ad < NW) mb[1-msel][ad] = int'($signed(d));
      else if (ad == NW) mk[1-msel] = int'(d[2:0]);
    end
    if (rf) msel = 1 - msel;
  endtask

  task automatic step(input bit v, input logic [13:0] a, input logic [13:0] b,
                      input bit we, input int ad, input logic [15:0] d,
                      input bit rf, input string tag);
    @(negedge clk);
    in_valid = v; x1 = a; x2 = b;
    cw_en = we; cw_addr = 6'(ad); cw_data = d; refresh = rf;
    model(v, int'($signed(a)), int'($signed(b)), we, ad, d, rf);
    @(posedge clk);
    #2;
    chk(out_valid == eov, "R3", "out_valid", longint'(out_valid), longint'(eov));
    chk(y1 == ey1, tag, "y1", longint'(y1), longint'(ey1));
    chk(y2 == ey2, tag, "y2", longint'(y2), longint'(ey2));
    chk(kh_out == ekh, "R9", "kh_out", longint'(kh_out), longint'(ekh));
  endtask

  function automatic logic [13:0] rs();
    return 14'($urandom);
  endfunction

  initial begin
    for (int i = 0; i < NW; i++) begin mb[0][i] = 0; mb[1][i] = 0; end
    mk[0] = 0; mk[1] = 0;
    for (int k = 0; k < NT; k++) begin hx1[k] = 0; hx2[k] = 0; end

    repeat (3) @(posedge clk);
    #2;
    chk(out_valid == 1'b0, "R1", "out_valid", longint'(out_valid), 0);
    chk(y1 == '0, "R1", "y1", longint'(y1), 0);
    chk(y2 == '0, "R1", "y2", longint'(y2), 0);
    chk(kh_out == '0, "R1", "kh_out", longint'(kh_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1, 14'd100, 14'd7, 0, 0, '0, 0, "R1");

    // profile A into shadow while streaming on the zero profile
    for (int i = 0; i < NW; i++) step(1, rs(), rs(), 1, i, 16'($urandom), 0, "R6");
    step(1, rs(), rs(), 1, NW, 16'd1, 0, "R6");
    step(1, rs(), rs(), 0, 0, '0, 1, "R7");

    // flush, then impulses on each stream to walk out the taps
    for (int i = 0; i < NT; i++) step(1, '0, '0, 0, 0, '0, 0, "R5");
    step(1, 14'd1, '0, 0, 0, '0, 0, "R5");
    for (int i = 0; i < NT; i++) step(1, '0, '0, 0, 0, '0, 0, "R5");
    step(1, '0, 14'd1, 0, 0, '0, 0, "R5");
    for (int i = 0; i < NT; i++) step(1, '0, '0, 0, 0, '0, 0, "R5");

    // stream with idle gaps
    for (int i = 0; i < 40; i++) step(1'($urandom), rs(), rs(), 0, 0, '0, 0, "R4");
    for (int i = 0; i < 30; i++) step(1, rs(), rs(), 0, 0, '0, 0, "R2");

    // profile B with kh=3 loaded during traffic, swap on a valid sample
    for (int i = 0; i < NW; i++) step(1'($urandom), rs(), rs(), 1, i, 16'($urandom), 0, "R6");
    step(1, rs(), rs(), 1, NW, 16'd3, 0, "R6");
    step(1, rs(), rs(), 0, 0, '0, 1, "R7");
    for (int i = 0; i < 12; i++) step(1, rs(), rs(), 0, 0, '0, 0, "R7");

    // second swap with no writes restores profile A
    step(1, rs(), rs(), 0, 0, '0, 1, "R10");
    for (int i = 0; i < 12; i++) step(1, rs(), rs(), 0, 0, '0, 0, "R10");

    // writes to unused addresses, then swap back to B
    for (int a = NW + 1; a < 64; a++) step(1, rs(), rs(), 1, a, 16'($urandom), 0, "R11");
    step(1, rs(), rs(), 0, 0, '0, 1, "R11");
    for (int i = 0; i < 12; i++) step(1, rs(), rs(), 0, 0, '0, 0, "R11");

    // write coinciding with refresh reaches the newly active bank
    step(1, rs(), rs(), 1, NW, 16'd5, 1, "R8");
    for (int i = 0; i < 6; i++) step(1, rs(), rs(), 0, 0, '0, 0, "R8");
    step(1, rs(), rs(), 1, 4, 16'h7fff, 1, "R8");
    for (int i = 0; i < 10; i++) step(1, rs(), rs(), 0, 0, '0, 0, "R8");

    // full-scale negatives with the largest exponent force wraparound
    for (int i = 0; i < NW; i++) step(0, '0, '0, 1, i, 16'h8000, 0, "R2");
    step(0, '0, '0, 1, NW, 16'd7, 0, "R2");
    step(1, 14'h2000, 14'h2000, 0, 0, '0, 1, "R2");
    for (int i = 0; i < 12; i++) step(1, 14'h2000, 14'h2000, 0, 0, '0, 0, "R2");
    step(0, '0, '0, 0, 0, '0, 0, "R4");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule